// File: doc/BRIEF.md
# Programmable Video Clock Divider Tree

This block derives the pixel-rate clock enables for a video pipeline from one of several source clocks. It is modelled entirely as single-cycle clock-enable pulses on one system clock. A 3-bit source selector picks one of eight source tick inputs. A programmable integer divider counts ticks of that source and emits one main tick every N of them. A bank of five post-divider taps at ratios 1, 2, 4, 6 and 12 is derived from the main tick. One shared phase counter drives every tap, so the edges of all taps line up. Each tap has its own gate. Each of three consumers has its own 4-bit selector and a final enable: the interlaced encoder, the progressive encoder and the HDMI transmitter pixel path.

Software configures the block through a plain write port with four word addresses. Bring-up follows a fixed order. First program the divider ratio, the tap gates and the routing. Then release the divider by clearing its reset bit and setting its enable bit in the same write. Set the master enable last. Pulsing the soft-reset bit restarts the tree in phase. The ratio, gate and routing fields are double-buffered: a write lands in a shadow copy and becomes active only at the next main-divider boundary, or at once while the tree is stopped. This means a reconfiguration can never produce a runt pulse. The block carries no data stream, so it has no valid/ready interface. Every pin is a plain control or enable pin.

Top module: `vclk_tree`

## Requirements
- R1: With ratio field D (address 1, bits [DIV_W-1:0]) and a tick on the selected source in every cycle, a main tick occurs on every (D+1)-th source tick. The /1 tap pulses once per main tick, one cycle after the main tick.
- R2: The source field (address 0, bits [4:2]) selects which bit of `src_tick` is counted. Ticks on every other bit have no effect on any output.
- R3: Taps 0..4 pulse on every 1st, 2nd, 4th, 6th and 12th main tick. All of them pulse together on the first main tick after a restart.
- R4: A tap whose gate bit is 0 (address 2, bit i for tap i) never pulses, and no consumer routed to it pulses.
- R5: Consumer selector codes 0..4 route the /1, /2, /4, /6 and /12 taps. The selector fields sit at address 3: bits [3:0] interlaced, [7:4] progressive, [11:8] HDMI.
- R6: Selector codes 5 to 15 hold that consumer output low.
- R7: Each consumer pulses only while its own enable bit is set (address 3, bits 12, 13 and 14 for interlaced, progressive and HDMI). Clearing it silences only that consumer.
- R8: While the master enable (address 0, bit 0) is clear, all outputs stay low and the counters sit at zero. Master enable is clear after reset.
- R9: While soft reset (address 0, bit 1) is set, all outputs stay low. After it is cleared, the first main tick pulses every gated tap together.
- R10: The divider runs only when its enable (address 1, bit 8) is set and its reset (address 1, bit 9) is clear. Divider reset is set after reset. A single write that clears the reset and sets the enable restarts the divider from count zero.
- R11: New ratio, gate and routing values take effect only at a main-divider boundary, or immediately while the tree is stopped. The main tick that follows a write still uses the old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 8 | One enable pulse input per candidate source clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address of the register written |
| wr_data | input | 16 | Write data |
| tap_ce | output | 5 | Gated tap pulses, bit i for tap i (/1,/2,/4,/6,/12) |
| enci_ce | output | 1 | Interlaced encoder clock enable |
| encp_ce | output | 1 | Progressive encoder clock enable |
| hdmi_ce | output | 1 | HDMI transmitter pixel clock enable |

## Verification
The bench builds the block with the ratio field narrowed to DIV_W = 4 and the other parameters left at their defaults. The narrower field keeps the full ratio range small, so random writes regularly reach the maximum ratio of 16 and its wrap. A full 12-tick tap cycle then fits in a few hundred clocks, so random runs pass through many /12 periods and many reconfigurations that land mid-period. The random selector values cover the out-of-range codes 5 to 15 as often as the valid ones.

// File: rtl/vclk_pkg.sv
package vclk_pkg;
  localparam int NUM_TAPS = 5;
  localparam int NUM_CONS = 3;
  localparam int SEL_W    = 4;
  localparam int PH_MOD   = 12;           // least common multiple of tap ratios
  localparam int PH_W     = $clog2(PH_MOD);

  // register word addresses
  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_DIV   = 2'd1;
  localparam logic [1:0] A_GATE  = 2'd2;
  localparam logic [1:0] A_ROUTE = 2'd3;

  // field positions
  localparam int CTRL_RUN_B  = 0;
  localparam int CTRL_SRST_B = 1;
  localparam int CTRL_SRC_LO = 2;
  localparam int DIV_EN_B    = 8;
  localparam int DIV_RST_B   = 9;
  localparam int ROUTE_EN_LO = 12;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             en;
  } cons_cfg_t;

  function automatic int tap_ratio(input int idx);
    case (idx)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 6;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/vclk_regs.sv
module vclk_regs
  import vclk_pkg::*;
#(
  parameter int SRC_W  = 3,
  parameter int DIV_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [1:0]                   wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         load,
  output logic                         master_en,
  output logic                         soft_rst,
  output logic                         div_en,
  output logic                         div_rst,
  output logic [SRC_W-1:0]             src_sel,
  output logic [DIV_W-1:0]             act_div,
  output logic [NUM_TAPS-1:0]          act_gate,
  output cons_cfg_t [NUM_CONS-1:0]     act_cons
);
  logic [DIV_W-1:0]        sh_div;
  logic [NUM_TAPS-1:0]     sh_gate;
  cons_cfg_t [NUM_CONS-1:0] sh_cons;

  // direct control fields and shadow copies
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_en <= 1'b0;
      soft_rst  <= 1'b0;
      div_en    <= 1'b0;
      div_rst   <= 1'b1;
      src_sel   <= '0;
      sh_div    <= '0;
      sh_gate   <= '0;
      sh_cons   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          master_en <= wr_data[CTRL_RUN_B];
          soft_rst  <= wr_data[CTRL_SRST_B];
          src_sel   <= wr_data[CTRL_SRC_LO +: SRC_W];
        end
        A_DIV: begin
          sh_div  <= wr_data[DIV_W-1:0];
          div_en  <= wr_data[DIV_EN_B];
          div_rst <= wr_data[DIV_RST_B];
        end
        A_GATE: sh_gate <= wr_data[NUM_TAPS-1:0];
        default: begin
          for (int c = 0; c < NUM_CONS; c++) begin
            sh_cons[c].sel <= wr_data[c*SEL_W +: SEL_W];
            sh_cons[c].en  <= wr_data[ROUTE_EN_LO + c];
          end
        end
      endcase
    end
  end

  // active copies move only at a divider boundary or while stopped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div  <= '0;
      act_gate <= '0;
      act_cons <= '0;
    end else if (load) begin
      act_div  <= sh_div;
      act_gate <= sh_gate;
      act_cons <= sh_cons;
    end
  end

  // R11
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_div) && $stable(act_gate) && $stable(act_cons)));
endmodule

// File: rtl/vclk_main_div.sv
module vclk_main_div #(
  parameter int SRC_W = 3,
  parameter int DIV_W = 8,
  localparam int NUM_SRC = 1 << SRC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SRC_W-1:0]   src_sel,
  input  logic [DIV_W-1:0]   div_m1,
  output logic               tick
);
  logic [DIV_W-1:0] cnt;
  logic             sel_tick;
  logic             at_end;

  always_comb begin
    sel_tick = src_tick[src_sel];
    at_end   = (cnt == div_m1);
    tick     = run && sel_tick && at_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (sel_tick) cnt <= at_end ? '0 : cnt + 1'b1;
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= div_m1);

  // R10
  stopped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/vclk_taps.sv
module vclk_taps
  import vclk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                tick,
  input  logic [NUM_TAPS-1:0] gate,
  output logic [NUM_TAPS-1:0] live,
  output logic [NUM_TAPS-1:0] tap_ce
);
  logic [PH_W-1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ph <= '0;
    else if (!run) ph <= '0;
    else if (tick) ph <= (ph == PH_W'(PH_MOD-1)) ? '0 : ph + 1'b1;
  end

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int RATIO = tap_ratio(i);
    assign live[i] = tick && gate[i] && ((int'(ph) % RATIO) == 0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tap_ce[i] <= 1'b0;
      else        tap_ce[i] <= live[i];
    end

    // R4
    tap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tap_ce[i] |-> $past(gate[i]));
  end

  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ph) < PH_MOD);
endmodule

// File: rtl/vclk_route.sv
module vclk_route
  import vclk_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_TAPS-1:0]      live,
  input  cons_cfg_t [NUM_CONS-1:0] cfg,
  output logic [NUM_CONS-1:0]      cons_ce
);
  localparam int IDX_W = $clog2(NUM_TAPS);
  localparam int PAD_N = (1 << IDX_W) - NUM_TAPS;

  logic [(1<<IDX_W)-1:0] live_pad;
  assign live_pad = {{PAD_N{1'b0}}, live};

  for (genvar c = 0; c < NUM_CONS; c++) begin : g_cons
    logic             code_ok;
    logic [IDX_W-1:0] idx;
    logic             pick;

    always_comb begin
      code_ok = cfg[c].sel < SEL_W'(NUM_TAPS);
      idx     = cfg[c].sel[IDX_W-1:0];
      pick    = cfg[c].en && code_ok && live_pad[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cons_ce[c] <= 1'b0;
      else        cons_ce[c] <= pick;
    end

    // R6
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[c].sel >= SEL_W'(NUM_TAPS)) |=> !cons_ce[c]);

    // R7
    cons_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg[c].en |=> !cons_ce[c]);
  end
endmodule

// File: rtl/vclk_tree.sv
module vclk_tree
  import vclk_pkg::*;
#(
  parameter int SRC_W  = 3,
  parameter int DIV_W  = 8,
  parameter int DATA_W = 16,
  localparam int NUM_SRC = 1 << SRC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [NUM_TAPS-1:0] tap_ce,
  output logic               enci_ce,
  output logic               encp_ce,
  output logic               hdmi_ce
);
  logic master_en, soft_rst, div_en, div_rst, run, tick, load;
  logic [SRC_W-1:0]         src_sel;
  logic [DIV_W-1:0]         act_div;
  logic [NUM_TAPS-1:0]      act_gate, live;
  cons_cfg_t [NUM_CONS-1:0] act_cons;
  logic [NUM_CONS-1:0]      cons_ce;

  assign run  = master_en && div_en && !div_rst && !soft_rst;
  assign load = !run || tick;

  vclk_regs #(.SRC_W(SRC_W), .DIV_W(DIV_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(load), .master_en(master_en),
    .soft_rst(soft_rst), .div_en(div_en), .div_rst(div_rst),
    .src_sel(src_sel), .act_div(act_div), .act_gate(act_gate),
    .act_cons(act_cons));

  vclk_main_div #(.SRC_W(SRC_W), .DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .src_tick(src_tick),
    .src_sel(src_sel), .div_m1(act_div), .tick(tick));

  vclk_taps u_taps (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .gate(act_gate),
    .live(live), .tap_ce(tap_ce));

  vclk_route u_route (
    .clk(clk), .rst_n(rst_n), .live(live), .cfg(act_cons),
    .cons_ce(cons_ce));

  assign enci_ce = cons_ce[0];
  assign encp_ce = cons_ce[1];
  assign hdmi_ce = cons_ce[2];

  // R8
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cons_ce != '0) || (tap_ce != '0)) |-> $past(master_en));

  // R9
  soft_rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> ((tap_ce == '0) && (cons_ce == '0)));
endmodule

// File: tb/vclk_tree_bench.sv
`timescale 1ns/1ps
module vclk_tree_bench;
  localparam int DIV_W = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_tick = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  tap_ce;
  logic        enci_ce, encp_ce, hdmi_ce;

  int n_chk = 0, n_bad = 0;
  int cnt_tap[5];
  int cnt_cons[3];
  int cyc_n = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vclk_tree #(.DIV_W(DIV_W)) u_vclk_tree (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .tap_ce(tap_ce),
    .enci_ce(enci_ce), .encp_ce(encp_ce), .hdmi_ce(hdmi_ce));

  // ---------------- reference model built from the requirements -------------
  bit        m_run_en, m_srst, m_den, m_drst;
  bit [2:0]  m_src;
  bit [3:0]  sh_div, a_div, m_cnt;
  bit [4:0]  sh_gate, a_gate;
  bit [14:0] sh_route, a_route;
  int        m_ph;
  bit [4:0]  e_tap;
  bit [2:0]  e_cons;

  function automatic int ratio(input int i);
    case (i) 0: return 1; 1: return 2; 2: return 4; 3: return 6; default: return 12; endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run_en = 0; m_srst = 0; m_den = 0; m_drst = 1; m_src = 0;
      sh_div = 0; a_div = 0; m_cnt = 0; sh_gate = 0; a_gate = 0;
      sh_route = 0; a_route = 0; m_ph = 0; e_tap = 0; e_cons = 0;
    end else begin
      bit run, st, tk;
      bit [4:0] hit;
      run = m_run_en && m_den && !m_drst && !m_srst;
      st  = src_tick[m_src];
      tk  = run && st && (m_cnt == a_div);
      for (int i = 0; i < 5; i++) hit[i] = tk && ((m_ph % ratio(i)) == 0) && a_gate[i];
      e_tap = hit;
      for (int c = 0; c < 3; c++) begin
        int s;
        s = int'(a_route[c*4 +: 4]);
        e_cons[c] = a_route[12+c] && (s < 5) && hit[s % 8 < 5 ? s : 0];
      end
      if (!run) m_cnt = 0;
      else if (st) m_cnt = (m_cnt == a_div) ? 4'd0 : m_cnt + 4'd1;
      if (!run) m_ph = 0;
      else if (tk) m_ph = (m_ph == 11) ? 0 : m_ph + 1;
      if (!run || tk) begin a_div = sh_div; a_gate = sh_gate; a_route = sh_route; end
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin m_run_en = wr_data[0]; m_srst = wr_data[1]; m_src = wr_data[4:2]; end
          2'd1: begin sh_div = wr_data[3:0]; m_den = wr_data[8]; m_drst = wr_data[9]; end
          2'd2: sh_gate = wr_data[4:0];
          default: sh_route = wr_data[14:0];
        endcase
      end
    end
  end

  // ---------------- helpers ---------------------------------------------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) begin
      n_chk++;
      if (tap_ce !== e_tap || {hdmi_ce, encp_ce, enci_ce} !== e_cons) begin
        n_bad++;
        $display("FAIL model R5 actual=%0d expected=%0d",
                 {hdmi_ce, encp_ce, enci_ce, tap_ce}, {e_cons, e_tap});
      end
    end
    for (int i = 0; i < 5; i++) cnt_tap[i] += int'(tap_ce[i]);
    cnt_cons[0] += int'(enci_ce);
    cnt_cons[1] += int'(encp_ce);
    cnt_cons[2] += int'(hdmi_ce);
  endtask

  task automatic clr();
    for (int i = 0; i < 5; i++) cnt_tap[i] = 0;
    for (int c = 0; c < 3; c++) cnt_cons[c] = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic run_src(input logic [7:0] pat, input int n);
    src_tick = pat;
    for (int k = 0; k < n; k++) cyc();
    src_tick = '0;
    for (int k = 0; k < 3; k++) cyc();
  endtask

  task automatic restart();
    src_tick = '0;
    wr(2'd0, 16'h000F);
    wr(2'd0, 16'h000D);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc_n);
      summary();
    end
  end

  // ---------------- stimulus --------------------------------------------------
  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R8: reset state, master off
    chk(tap_ce == 0 && !enci_ce && !encp_ce && !hdmi_ce, "R8 reset", int'(tap_ce), 0);

    // configure while stopped, release divider, master last
    wr(2'd1, 16'h0102);
    wr(2'd2, 16'h001F);
    wr(2'd3, 16'h7340);
    wr(2'd0, 16'h000D);
    clr();
    run_src(8'h08, 72);
    // R1 / R3
    chk(cnt_tap[0] == 24, "R1 div1 count", cnt_tap[0], 24);
    chk(cnt_tap[1] == 12 && cnt_tap[2] == 6, "R3 /2 /4", cnt_tap[1]*100+cnt_tap[2], 1206);
    chk(cnt_tap[3] == 4 && cnt_tap[4] == 2, "R3 /6 /12", cnt_tap[3]*100+cnt_tap[4], 402);
    // R5
    chk(cnt_cons[0] == 24 && cnt_cons[1] == 2 && cnt_cons[2] == 4, "R5 routing",
        cnt_cons[0]*10000+cnt_cons[1]*100+cnt_cons[2], 240204);

    // R2: other sources ignored
    clr();
    run_src(8'hF7, 40);
    chk(cnt_tap[0] == 0 && cnt_cons[0] == 0, "R2 other source", cnt_tap[0], 0);

    // R9: soft reset mid-period
    src_tick = 8'h08;
    repeat (5) cyc();
    wr(2'd0, 16'h000F);
    clr();
    repeat (6) cyc();
    chk(cnt_tap[0] == 0 && cnt_cons[0] == 0, "R9 quiet", cnt_tap[0], 0);
    wr(2'd0, 16'h000D);
    begin
      int seen = 0;
      for (int k = 0; k < 10 && seen == 0; k++) begin
        cyc();
        if (tap_ce != 0) begin
          seen = 1;
          chk(tap_ce == 5'h1F && enci_ce && encp_ce && hdmi_ce, "R9 aligned",
              int'(tap_ce), 31);
        end
      end
      chk(seen == 1, "R9 restart", seen, 1);
    end
    src_tick = '0;

    // R4: gates
    wr(2'd2, 16'h000A);
    restart();
    clr();
    run_src(8'h08, 72);
    chk(cnt_tap[0] == 0 && cnt_tap[2] == 0 && cnt_tap[4] == 0, "R4 gated off",
        cnt_tap[0]+cnt_tap[2]+cnt_tap[4], 0);
    chk(cnt_tap[1] == 12 && cnt_tap[3] == 4, "R4 gated on", cnt_tap[1]*100+cnt_tap[3], 1204);
    chk(cnt_cons[0] == 0 && cnt_cons[1] == 0 && cnt_cons[2] == 4, "R4 consumer of gated tap",
        cnt_cons[0]*100+cnt_cons[1], 0);

    // R6 / R7
    wr(2'd2, 16'h001F);
    wr(2'd3, 16'h5119);
    restart();
    clr();
    run_src(8'h08, 72);
    chk(cnt_cons[0] == 0, "R6 code 9", cnt_cons[0], 0);
    chk(cnt_cons[1] == 0, "R7 disabled", cnt_cons[1], 0);
    chk(cnt_cons[2] == 12, "R7 other stays", cnt_cons[2], 12);

    // R10: divider reset then single-write release
    src_tick = 8'h08;
    wr(2'd1, 16'h0302);
    clr();
    repeat (30) cyc();
    chk(cnt_tap[0] == 0, "R10 held", cnt_tap[0], 0);
    wr(2'd1, 16'h0102);
    clr();
    run_src(8'h08, 72);
    chk(cnt_tap[0] == 24, "R10 released", cnt_tap[0], 24);

    // R11: write after a tick still lets the next tick use old gate
    wr(2'd1, 16'h0107);
    restart();
    src_tick = 8'h08;
    begin
      int guard = 0;
      while (tap_ce[0] == 1'b0 && guard < 40) begin cyc(); guard++; end
    end
    clr();
    wr(2'd2, 16'h0000);
    repeat (20) cyc();
    chk(cnt_tap[0] == 1, "R11 boundary", cnt_tap[0], 1);
    src_tick = '0;

    // R8: master off
    wr(2'd2, 16'h001F);
    wr(2'd0, 16'h000C);
    clr();
    run_src(8'h08, 30);
    chk(cnt_tap[0] == 0 && cnt_cons[2] == 0, "R8 master off", cnt_tap[0], 0);

    // random phase against the model
    wr(2'd0, 16'h000D);
    for (int k = 0; k < 4000; k++) begin
      src_tick = 8'($urandom());
      if (($urandom() % 20) == 0) begin
        logic [1:0]  a;
        logic [15:0] d;
        a = 2'($urandom());
        d = 16'($urandom());
        if (a == 2'd0) begin
          d[0] = (($urandom() % 10) != 0);
          d[1] = (($urandom() % 20) == 0);
        end else if (a == 2'd1) begin
          d[8] = (($urandom() % 10) != 0);
          d[9] = (($urandom() % 15) == 0);
        end
        wr(a, d);
      end else begin
        cyc();
      end
    end

    done = 1'b1;
    summary();
  end
endmodule